// File: doc/BRIEF.md
# SPI Master Transmit Buffer with DMA Fill Modes

This block is the transmit half of an SPI master. A 16-bit holding register sits on a simple register bus and feeds a 16-bit shift register, which drives the serial data line in SPI mode 0. The serial clock comes from a 4-bit programmable divider. A busy output marks the frame in progress, and a full flag marks a word that is waiting for the shifter.

A two-bit mode input selects where the holding register gets its data. In processor mode, a bus write fills the register and starts a frame. In DMA-fill mode, the block raises a request whenever the register is empty, and an acknowledge delivers the next word. In repeat mode, the block keeps resending whatever the register holds, frame after frame, with an idle gap between frames. A bus write in repeat mode changes the word that is sent from then on.

Top module: `spitx_core`

## Requirements
- R1: After a synchronous reset, the holding register reads 0x0000, and `buf_full`, `busy`, `sclk`, `mosi` and `dma_req` are all low.
- R2: In processor mode (`mode_sel` 00 or 11), a bus write sets `buf_full` at that clock edge. If the shifter is idle, the word moves into the shifter at the next edge: `busy` rises and `buf_full` clears.
- R3: A frame is 16 bits, sent MSB first. `mosi` changes only when the frame is loaded or on a falling `sclk`, so it is stable while `sclk` is high. `sclk` is low whenever `busy` is low and at the start of every frame.
- R4: With divider value N, each `sclk` half period lasts N+1 clock cycles. `busy` stays high for exactly 32·(N+1) cycles, and `sclk` is high for 16·(N+1) of them.
- R5: `bus_rdata` equals the holding register while `bus_rd` is high and is 0 while it is low. Reads never start a frame or change `buf_full`.
- R6: If several writes land while a frame is shifting, only the last one is sent in the next frame, and `buf_full` stays high until that word is loaded.
- R7: In DMA-fill mode (`mode_sel` 01), `dma_req` is high while the holding register is empty. When `dma_ack` is high together with `dma_req`, `dma_data` is stored, `buf_full` is set, and `dma_req` is low in the following cycle.
- R8: In DMA-fill mode, a bus write replaces a DMA word that is still pending, and the written value is the one sent. If a write and an acknowledge fall in the same cycle, the write wins.
- R9: In DMA-fill mode, no frame starts while no word has been delivered. `busy` stays low and `dma_req` stays high.
- R10: In repeat mode (`mode_sel` 10), the held word is sent on every frame without further writes. A write during a frame changes the word sent in later frames.
- R11: Between two consecutive frames, `busy` is low for at least 2·(N+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00/11 processor, 01 DMA fill, 10 repeat |
| clk_div | input | 4 | Divider N; sclk = clk / (2·(N+1)) |
| bus_wr | input | 1 | Write strobe for the holding register |
| bus_rd | input | 1 | Read strobe; gates bus_rdata |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Holding register contents while bus_rd is high |
| dma_req | output | 1 | Request for the next word in DMA-fill mode |
| dma_ack | input | 1 | Acknowledge; dma_data is valid |
| dma_data | input | 16 | Word delivered by DMA |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, MSB first |
| busy | output | 1 | High while a frame is shifting |
| buf_full | output | 1 | Holding register holds a word not yet loaded |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. Each check is placed at the cycle where its result is due:
- A write or acknowledge shows in `buf_full`, `dma_req` and `bus_rdata` one edge later.
- When the shifter is idle, the load shows in `busy` one edge after that.
- The first rising `sclk` comes N+1 cycles after the load.
- `busy` falls 32·(N+1) cycles after the load.
- The next frame in repeat mode loads 2·(N+1)+1 cycles after `busy` falls.

An independent receiver shifts `mosi` on every rising `sclk`. The bench compares the word it collects with the expected word, counts the busy and high-clock cycles against the divider, and measures the gap between frames against its lower bound.

// File: rtl/spitx_pkg.sv
package spitx_pkg;

    localparam int WORD_W = 16;
    localparam int DIV_W  = 4;

    typedef enum logic [1:0] {
        MODE_CPU     = 2'b00,
        MODE_DMA_TX  = 2'b01,
        MODE_REPEAT  = 2'b10,
        MODE_CPU_ALT = 2'b11
    } tx_mode_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'b00,
        SH_SHIFT = 2'b01,
        SH_GAP   = 2'b10
    } sh_state_e;

    typedef struct packed {
        logic dma_fill;   // holding register refilled by DMA handshake
        logic resend;     // shifter reloads even when no new word arrived
    } mode_cfg_t;

    function automatic mode_cfg_t decode_mode(tx_mode_e m);
        mode_cfg_t c;
        c.dma_fill = (m == MODE_DMA_TX);
        c.resend   = (m == MODE_REPEAT);
        return c;
    endfunction

endpackage

// File: rtl/spitx_baud.sv
module spitx_baud #(
    parameter int DIV_W = spitx_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // one pulse every div+1 cycles while running: marks a half-period end
    assign tick = run && (cnt_q == div);

endmodule

// File: rtl/spitx_txbuf.sv
module spitx_txbuf
    import spitx_pkg::*;
#(
    parameter int DATA_W = spitx_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_cfg_t         cfg,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_data,
    output logic              dma_req,
    input  logic              shf_idle,
    output logic              load_go,
    output logic [DATA_W-1:0] load_word,
    output logic              full
);
    logic [DATA_W-1:0] hold_q;
    logic              full_q;
    logic              ack_hold_q;
    logic              dma_take;

    assign dma_req   = cfg.dma_fill && !full_q && !ack_hold_q;
    assign dma_take  = dma_ack && dma_req;
    assign load_go   = shf_idle && (cfg.resend || full_q);
    assign load_word = hold_q;
    assign full      = full_q;
    assign bus_rdata = bus_rd ? hold_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            full_q     <= 1'b0;
            ack_hold_q <= 1'b0;
        end else begin
            ack_hold_q <= dma_take;
            if (bus_wr) begin
                hold_q <= bus_wdata;     // processor write beats a DMA word
                full_q <= 1'b1;
            end else if (dma_take) begin
                hold_q <= dma_data;
                full_q <= 1'b1;
            end else if (load_go) begin
                full_q <= 1'b0;
            end
        end
    end

    // R7: request is withdrawn in the cycle after an accepted acknowledge
    a_r7_req_drops: assert property (@(posedge clk) disable iff (rst)
        dma_take |=> !dma_req);

    // R2: handing a word to the shifter empties the holding register
    a_r2_load_clears_full: assert property (@(posedge clk) disable iff (rst)
        (load_go && !bus_wr && !dma_take) |=> !full);

    // R6: a write always leaves a pending word behind it
    a_r6_write_pends: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> full);

endmodule

// File: rtl/spitx_shifter.sv
module spitx_shifter
    import spitx_pkg::*;
#(
    parameter int DATA_W = spitx_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_go,
    input  logic [DATA_W-1:0] load_word,
    input  logic              tick,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              idle
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    sh_state_e         state_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_q;
    logic              sclk_q;
    logic              gap_half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SH_IDLE;
            shreg_q    <= '0;
            bit_q      <= '0;
            sclk_q     <= 1'b0;
            gap_half_q <= 1'b0;
        end else begin
            case (state_q)
                SH_IDLE: begin
                    if (load_go) begin
                        shreg_q <= load_word;
                        bit_q   <= '0;
                        sclk_q  <= 1'b0;
                        state_q <= SH_SHIFT;
                    end
                end
                SH_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;               // sampling edge
                        end else begin
                            sclk_q <= 1'b0;               // launch edge
                            if (bit_q == LAST_BIT) begin
                                state_q    <= SH_GAP;
                                gap_half_q <= 1'b0;
                            end else begin
                                bit_q   <= bit_q + 1'b1;
                                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                SH_GAP: begin
                    if (tick) begin
                        if (gap_half_q) begin
                            state_q <= SH_IDLE;
                        end else begin
                            gap_half_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

    assign busy = (state_q == SH_SHIFT);
    assign idle = (state_q == SH_IDLE);
    assign sclk = sclk_q;
    assign mosi = busy & shreg_q[DATA_W-1];

    // R3: clock idles low outside a frame
    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    // R3: data is held across the whole high phase
    a_r3_mosi_steady: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R3: every frame starts with the clock low
    a_r3_frame_starts_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !sclk);

    // R11: a frame is never followed immediately by another
    a_r11_gap_after_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> !busy);

endmodule

// File: rtl/spitx_core.sv
module spitx_core
    import spitx_pkg::*;
#(
    parameter int DATA_W = spitx_pkg::WORD_W,
    parameter int DIV_W  = spitx_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_data,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              buf_full
);
    mode_cfg_t         cfg;
    logic              load_go;
    logic [DATA_W-1:0] load_word;
    logic              shf_idle;
    logic              tick;

    assign cfg = decode_mode(tx_mode_e'(mode_sel));

    spitx_txbuf #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dma_ack   (dma_ack),
        .dma_data  (dma_data),
        .dma_req   (dma_req),
        .shf_idle  (shf_idle),
        .load_go   (load_go),
        .load_word (load_word),
        .full      (buf_full)
    );

    spitx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (!shf_idle),
        .div  (clk_div),
        .tick (tick)
    );

    spitx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk       (clk),
        .rst       (rst),
        .load_go   (load_go),
        .load_word (load_word),
        .tick      (tick),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (busy),
        .idle      (shf_idle)
    );

endmodule

// File: tb/sim_spitx_core.sv
`timescale 1ns/1ps
module sim_spitx_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_sel;
    logic [3:0]  clk_div;
    logic        bus_wr, bus_rd, dma_ack;
    logic [15:0] bus_wdata, dma_data;
    logic [15:0] bus_rdata;
    logic        dma_req, sclk, mosi, busy, buf_full;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spitx_core u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .clk_div(clk_div),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dma_req(dma_req), .dma_ack(dma_ack),
        .dma_data(dma_data), .sclk(sclk), .mosi(mosi), .busy(busy),
        .buf_full(buf_full)
    );

    // independent receiver: sample on rising serial clock
    logic [15:0] cap = '0;
    int unsigned ncap = 0;
    always @(posedge sclk) begin
        cap  <= {cap[14:0], mosi};
        ncap <= ncap + 1;
    end

    // mode 0 line discipline monitor
    int unsigned bad_edge = 0;
    logic p_sclk = 1'b0, p_mosi = 1'b0;
    always @(negedge clk) begin
        if (sclk && p_sclk && (mosi !== p_mosi)) bad_edge <= bad_edge + 1;
        if (sclk && !busy) bad_edge <= bad_edge + 1;
        p_sclk <= sclk;
        p_mosi <= mosi;
    end

    typedef struct packed {
        logic [3:0]  div;
        logic [15:0] word;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd0,  16'hA5C3},
        '{4'd1,  16'h8001},
        '{4'd3,  16'h7FFE},
        '{4'd0,  16'hFFFF},
        '{4'd2,  16'h1234},
        '{4'd15, 16'h0000}
    };

    task automatic step;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_busy(output int unsigned waited);
        waited = 0;
        while (!busy && waited < 3000) begin
            step;
            waited++;
        end
    endtask

    task automatic run_frame(output int unsigned len, output int unsigned hi);
        len = 0;
        hi  = 0;
        while (busy && len < 6000) begin
            len++;
            if (sclk) hi++;
            step;
        end
    endtask

    task automatic bus_write(input logic [15:0] w);
        bus_wr    = 1'b1;
        bus_wdata = w;
        step;
        bus_wr    = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned len, hi, w, s;
        rst = 1'b1; mode_sel = 2'b00; clk_div = 4'd0;
        bus_wr = 1'b0; bus_rd = 1'b1; dma_ack = 1'b0;
        bus_wdata = '0; dma_data = '0;
        repeat (3) step;
        rst = 1'b0;
        // R1 reset state
        chk("R1 rdata", bus_rdata, 16'h0000);
        chk("R1 full", buf_full, 0);
        chk("R1 busy", busy, 0);
        chk("R1 sclk", sclk, 0);
        chk("R1 mosi", mosi, 0);
        chk("R1 dma_req", dma_req, 0);
        repeat (4) step;
        chk("R1 no spontaneous frame", busy, 0);

        // table walk: processor mode, R2 R3 R4
        for (int i = 0; i < 6; i++) begin
            clk_div = VECS[i].div;
            repeat (40) step;
            s = ncap;
            bus_write(VECS[i].word);
            chk("R2 full after write", buf_full, 1);
            chk("R2 not yet busy", busy, 0);
            chk("R5 rdata after write", bus_rdata, VECS[i].word);
            step;
            chk("R2 busy after load", busy, 1);
            chk("R2 full cleared on load", buf_full, 0);
            run_frame(len, hi);
            chk("R3 word MSB first", cap, VECS[i].word);
            chk("R3 sixteen bits", ncap - s, 16);
            chk("R4 busy length", len, 32 * (VECS[i].div + 1));
            chk("R4 sclk high time", hi, 16 * (VECS[i].div + 1));
        end

        // R5: reads are passive
        clk_div = 4'd1;
        repeat (40) step;
        bus_rd = 1'b0;
        chk("R5 rdata gated low", bus_rdata, 0);
        for (int k = 0; k < 10; k++) begin
            bus_rd = k[0];
            step;
            chk("R5 read starts nothing", busy, 0);
        end
        bus_rd = 1'b1;
        step;
        chk("R5 rdata shows buffer", bus_rdata, 16'h0000);
        chk("R5 flag untouched", buf_full, 0);

        // R6: several writes during a frame, last one sent
        bus_write(16'hC001);
        wait_busy(w);
        bus_write(16'h2222);
        bus_write(16'h5A96);
        chk("R6 flag held during frame", buf_full, 1);
        chk("R6 last write visible", bus_rdata, 16'h5A96);
        run_frame(len, hi);
        chk("R6 first frame intact", cap, 16'hC001);
        wait_busy(w);
        chk("R11 gap processor mode", (w >= 4) ? 1 : 0, 1);
        chk("R6 flag cleared on reload", buf_full, 0);
        run_frame(len, hi);
        chk("R6 only last write sent", cap, 16'h5A96);
        repeat (40) step;

        // R7: DMA fill
        mode_sel = 2'b01;
        #0;
        chk("R7 request when empty", dma_req, 1);
        dma_ack = 1'b1; dma_data = 16'h3C5A;
        step;
        dma_ack = 1'b0;
        chk("R7 request drops after ack", dma_req, 0);
        chk("R7 full after ack", buf_full, 1);
        chk("R7 word stored", bus_rdata, 16'h3C5A);
        step;
        chk("R7 frame loaded", busy, 1);
        chk("R7 request back", dma_req, 1);
        run_frame(len, hi);
        chk("R7 DMA word sent", cap, 16'h3C5A);

        // R9: stall without a word
        repeat (60) begin
            step;
        end
        chk("R9 no frame without word", busy, 0);
        chk("R9 request still up", dma_req, 1);

        // R8: processor write replaces pending DMA word
        dma_ack = 1'b1; dma_data = 16'h1357;
        step;
        dma_ack = 1'b0;
        step;
        chk("R8 first frame started", busy, 1);
        dma_ack = 1'b1; dma_data = 16'hDEAD;
        step;
        dma_ack = 1'b0;
        chk("R8 DMA word pending", buf_full, 1);
        chk("R7 no request while full", dma_req, 0);
        bus_write(16'h0F0F);
        chk("R8 write replaced word", bus_rdata, 16'h0F0F);
        run_frame(len, hi);
        chk("R8 earlier frame intact", cap, 16'h1357);
        wait_busy(w);
        run_frame(len, hi);
        chk("R8 written word sent", cap, 16'h0F0F);
        repeat (40) step;
        // R8: same-cycle write and ack, write wins
        bus_wr = 1'b1; bus_wdata = 16'h6666;
        dma_ack = 1'b1; dma_data = 16'h9999;
        step;
        bus_wr = 1'b0; dma_ack = 1'b0;
        chk("R8 write beats ack", bus_rdata, 16'h6666);
        step;
        run_frame(len, hi);
        chk("R8 tie frame", cap, 16'h6666);
        repeat (40) step;

        // R10: repeat mode
        mode_sel = 2'b10;
        wait_busy(w);
        run_frame(len, hi);
        chk("R10 held word sent", cap, 16'h6666);
        wait_busy(w);
        chk("R11 gap repeat mode", (w >= 4) ? 1 : 0, 1);
        bus_write(16'hB00B);
        run_frame(len, hi);
        chk("R10 frame after write unchanged", cap, 16'h6666);
        wait_busy(w);
        run_frame(len, hi);
        chk("R10 new word resent", cap, 16'hB00B);
        wait_busy(w);
        run_frame(len, hi);
        chk("R10 resent again", cap, 16'hB00B);
        mode_sel = 2'b00;
        repeat (60) step;
        chk("R10 stops on mode change", busy, 0);

        chk("R3 mode 0 line discipline", bad_edge, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule